// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block times the clock line of an I2C master. It derives a slower internal clock tick from the system clock through a small prescaler. It then counts a whole SCL period on that tick and splits the period into a low half and a high half. The period is a fixed base of 20 internal ticks, plus 8 ticks for each step of a 6-bit period field, plus a compensation count. The compensation count stands for SCL fall time, SCL rise time and internal delay, already turned into internal ticks. Software works out all three field values from the target bus speed. The hardware only counts.

A single write port loads the clock-control word. A written word is held as pending and takes effect at the next SCL period boundary, so a period never changes length partway through. While `run` is high the divider produces back-to-back periods. When `run` drops, the current period finishes and SCL is then left released (high). The high half also watches the sampled bus clock. If a target holds SCL low, the high-phase count pauses until the line is seen high again. The byte controller uses `tick_int`, `tick_fall` and `tick_rise` to place its data changes and sampling.

The internal tick rate, which is the system clock divided by one plus the prescale field, is meant to stay below 20 MHz. Choosing a prescale value that meets this limit is left to software.

Top module: `scl_clk_div`

## Requirements
- R1: After reset, and at any time `run` is low with no period in progress, `scl_out` is 1 and `tick_int`, `tick_fall` and `tick_rise` are all 0.
- R2: While a period runs and the bus clock is not stretched, `tick_int` pulses once every (1 + prescale) system clocks, so the low half carries exactly as many pulses as it is ticks long.
- R3: With no stretching, one SCL period lasts (20 + 8·period + comp) · (1 + prescale) system clocks.
- R4: With P = 20 + 8·period + comp, the low half lasts ceil(P/2) internal ticks and the high half lasts floor(P/2) internal ticks, so the low half is the longer one when P is odd.
- R5: `tick_fall` is a one-cycle pulse in the first cycle in which `scl_out` is 0. `tick_rise` is a one-cycle pulse in the first cycle in which `scl_out` is 1 after a low half.
- R6: In the high half, each system clock in which `scl_in` is sampled 0 adds exactly one system clock to that half, and no `tick_int` pulse occurs in such a clock.
- R7: A word written through `cfg_we`/`cfg_wdata` does not change the period in progress. It is applied at the next period start, that is, the next `tick_fall`.
- R8: When `run` is 0 at the end of a high half, no new period starts. `scl_out` stays 1 and no ticks are produced until `run` returns to 1.
- R9: The clock-control word holds the prescale in bits [2:0], the period field in bits [8:3] and the compensation count in bits [12:9].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Keep producing SCL periods while high |
| cfg_we | input | 1 | Write strobe for the clock-control word |
| cfg_wdata | input | 13 | Clock-control word: comp[12:9], period[8:3], prescale[2:0] |
| scl_in | input | 1 | Synchronized level sampled from the bus SCL line |
| scl_out | output | 1 | SCL phase to drive: 0 pulls low, 1 releases |
| tick_int | output | 1 | Internal clock tick, one system clock wide |
| tick_fall | output | 1 | Pulse marking the start of a low half (period start) |
| tick_rise | output | 1 | Pulse marking the start of a high half |

## Verification
The bench builds the block with its default widths: a 3-bit prescale, a 6-bit period field and a 4-bit compensation field. These widths let it reach the largest period with the deepest prescale (4312 system clocks) as well as the shortest 20-tick period with no prescale. Compensation values of both parities drive P odd and even, which exercises the rounding between the two halves. Random stretch lengths in the high half test the pause logic, and rewriting the word at every period start shows that each period still uses the word written one period earlier.

// File: rtl/scl_clk_div.sv
module scl_clk_div #(
  parameter int PRE_W  = 3,
  parameter int PER_W  = 6,
  parameter int COMP_W = 4,
  parameter int BASE   = 20,
  parameter int STEP   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run,
  input  logic                          cfg_we,
  input  logic [PRE_W+PER_W+COMP_W-1:0] cfg_wdata,
  input  logic                          scl_in,
  output logic                          scl_out,
  output logic                          tick_int,
  output logic                          tick_fall,
  output logic                          tick_rise
);
  localparam int CFG_W = PRE_W + PER_W + COMP_W;
  localparam int MAXP  = BASE + STEP * ((1 << PER_W) - 1) + (1 << COMP_W) - 1;
  localparam int PW    = $clog2(MAXP + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} ph_t;

  ph_t              ph_q;
  logic [PRE_W-1:0] pre_q;
  logic [PW-1:0]    cnt_q;
  logic [CFG_W-1:0] act_q, pend_q;
  logic             pend_v_q;
  logic             in_low, in_high, stall, last_low, last_high, boundary;
  logic [PW-1:0]    per_len, low_len, high_len;

  function automatic logic [PW-1:0] len_of(input logic [CFG_W-1:0] c);
    return PW'(BASE) + PW'(STEP) * PW'(c[PRE_W +: PER_W]) + PW'(c[PRE_W+PER_W +: COMP_W]);
  endfunction

  assign per_len  = len_of(act_q);
  assign low_len  = (per_len + PW'(1)) >> 1;
  assign high_len = per_len >> 1;

  assign in_low    = (ph_q == S_LOW);
  assign in_high   = (ph_q == S_HIGH);
  assign stall     = in_high && !scl_in;
  assign tick_int  = (ph_q != S_IDLE) && !stall && (pre_q == act_q[PRE_W-1:0]);
  assign last_low  = in_low  && tick_int && (cnt_q == low_len  - PW'(1));
  assign last_high = in_high && tick_int && (cnt_q == high_len - PW'(1));
  assign boundary  = run && ((ph_q == S_IDLE) || last_high);
  assign scl_out   = !in_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= S_IDLE;
      pre_q     <= '0;
      cnt_q     <= '0;
      act_q     <= '0;
      pend_q    <= '0;
      pend_v_q  <= 1'b0;
      tick_fall <= 1'b0;
      tick_rise <= 1'b0;
    end else begin
      tick_fall <= boundary;
      tick_rise <= last_low;
      if (cfg_we) begin
        pend_q   <= cfg_wdata;
        pend_v_q <= 1'b1;
      end else if (boundary) begin
        pend_v_q <= 1'b0;
      end
      if (boundary) begin
        if (pend_v_q) act_q <= pend_q;
        ph_q  <= S_LOW;
        pre_q <= '0;
        cnt_q <= '0;
      end else if (last_low) begin
        ph_q  <= S_HIGH;
        pre_q <= '0;
        cnt_q <= '0;
      end else if (last_high) begin
        ph_q  <= S_IDLE;
        pre_q <= '0;
        cnt_q <= '0;
      end else if (tick_int) begin
        pre_q <= '0;
        cnt_q <= cnt_q + PW'(1);
      end else if (ph_q != S_IDLE && !stall) begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

module scl_clk_div_chk #(
  parameter int CFG_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             scl_in,
  input logic             scl_out,
  input logic             tick_int,
  input logic             tick_fall,
  input logic             tick_rise,
  input logic             in_low,
  input logic             in_high,
  input logic [CFG_W-1:0] act_cfg
);
  p_fall_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |-> !scl_out);
  p_rise_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |-> scl_out);
  p_fall_marked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_out) |-> tick_fall);
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_high && !scl_in) |=> (scl_out && !tick_fall));
  p_stall_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_high && !scl_in) |-> !tick_int);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_low && !in_high) |-> (scl_out && !tick_int));
  p_stay_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_low && !in_high && !run) |=> (scl_out && !tick_fall));
  p_cfg_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_cfg) |-> tick_fall);
endmodule

bind scl_clk_div scl_clk_div_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .scl_in(scl_in), .scl_out(scl_out),
  .tick_int(tick_int), .tick_fall(tick_fall), .tick_rise(tick_rise),
  .in_low(in_low), .in_high(in_high), .act_cfg(act_q)
);

// File: tb/scl_clk_div_bench.sv
module scl_clk_div_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cfg_we = 1'b0;
  logic [12:0] cfg_wdata = '0;
  logic        stretch = 1'b0;
  logic        scl_in;
  logic        scl_out, tick_int, tick_fall, tick_rise;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign scl_in = scl_out && !stretch;

  scl_clk_div u_scl_clk_div (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .scl_in(scl_in), .scl_out(scl_out), .tick_int(tick_int),
    .tick_fall(tick_fall), .tick_rise(tick_rise)
  );

  function automatic logic [12:0] pack(input int pre, input int per, input int comp);
    return {comp[3:0], per[5:0], pre[2:0]};
  endfunction
  function automatic int p_of(input logic [12:0] c);
    return 20 + 8 * int'(c[8:3]) + int'(c[12:9]);
  endfunction
  function automatic int d_of(input logic [12:0] c);
    return 1 + int'(c[2:0]);
  endfunction
  function automatic int lo_of(input logic [12:0] c);
    return (p_of(c) + 1) / 2;
  endfunction
  function automatic int hi_of(input logic [12:0] c);
    return p_of(c) / 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int k, output int lo, output int hi, output int nt,
                         output bit okf, output bit okr);
    okf = tick_fall && !scl_out;
    lo = 0; hi = 0; nt = 0;
    while (!scl_out && lo < 10000) begin
      lo++;
      if (tick_int) nt++;
      @(negedge clk);
      cfg_we = 1'b0;
    end
    okr = tick_rise;
    while (scl_out && !tick_fall && hi < 10000) begin
      hi++;
      stretch = (hi <= k);
      @(negedge clk);
    end
    stretch = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    logic [12:0] cur, nxt;
    int lo, hi, nt, k, seed;
    bit okf, okr, wrote, quiet;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    quiet = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!scl_out || tick_int || tick_fall || tick_rise) quiet = 1'b0;
    end
    chk(quiet, "R1 idle after reset", int'(quiet), 1);

    cur = pack(0, 0, 0);
    cfg_wdata = cur; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    run = 1'b1;
    while (!tick_fall) @(negedge clk);

    for (int i = 0; i < 34; i++) begin
      if (i == 0)      nxt = pack(7, 63, 15);
      else if (i == 1) nxt = pack(0, 0, 1);
      else if (i == 2) nxt = pack(1, 2, 2);
      else             nxt = pack($urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 15));
      wrote = (i % 5 != 4);
      k = (i > 3) ? int'($urandom_range(0, 4)) : 0;
      if (wrote) begin
        cfg_wdata = nxt; cfg_we = 1'b1;
      end
      measure(k, lo, hi, nt, okf, okr);
      chk(okf, "R5 fall pulse", int'(okf), 1);
      chk(okr, "R5 rise pulse", int'(okr), 1);
      chk(lo == lo_of(cur) * d_of(cur), "R4 R7 R9 low half", lo, lo_of(cur) * d_of(cur));
      chk(hi == hi_of(cur) * d_of(cur) + k, "R4 R6 high half", hi, hi_of(cur) * d_of(cur) + k);
      chk(lo + hi - k == p_of(cur) * d_of(cur), "R3 period", lo + hi - k, p_of(cur) * d_of(cur));
      chk(nt == lo_of(cur), "R2 internal ticks", nt, lo_of(cur));
      if (wrote) cur = nxt;
    end

    run = 1'b0;
    measure(0, lo, hi, nt, okf, okr);
    chk(lo == lo_of(cur) * d_of(cur), "R8 final low half", lo, lo_of(cur) * d_of(cur));
    chk(hi >= 10000, "R8 stays released", hi, 10000);
    quiet = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!scl_out || tick_int || tick_fall || tick_rise) quiet = 1'b0;
    end
    chk(quiet, "R1 R8 quiet when stopped", int'(quiet), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule